// File: doc/BRIEF.md
# Serial Frame Acknowledge Decision Unit

This block sits on the slave side of a multi-master serial bus, behind a bit-level receiver that has already recovered bit timing. It takes the decoded bits of one frame in order: a 12-bit master address, a 12-bit slave address, a 4-bit control code, an 8-bit byte count and that many 8-bit data bytes. Every field ends with one even-parity bit. After the parity bit of each field that owns an acknowledge slot, the unit decides whether this station answers ACK or NAK. A NAK on a directed frame aborts the frame, and the unit then waits for the next start-of-frame strobe.

The control-field decision is more than a parity check. It looks at the control code, the fill state of the local receive and transmit buffers, the master that sent the frame and a lock owner that persists across frames. The surrounding controller loads and clears the lock owner with strobes. A timing-error strobe from the bit receiver marks the current field as damaged.

Bits arrive on a valid/ready stream. A bit is taken on a clock edge where `bit_valid` and `bit_ready` are both high. The sender must hold `bit_valid` and `bit_data` steady until that edge. The unit lowers `bit_ready` only in the single cycle in which it presents an acknowledge decision. Outside a frame, bits are still taken and are thrown away.

Top module: `ackdec_unit`

## Requirements
- R1: A field passes parity when its data bits and its parity bit together hold an even number of ones. A parity failure gives NAK at that field's acknowledge slot. A failure in the master address is reported at the slave-address slot.
- R2: `ack_valid` pulses for one cycle, in the cycle after the parity bit of the slave address, the control field, the byte count or a data byte is taken. No pulse follows the master address. `ack_nak` is 0 for ACK and 1 for NAK.
- R3: On a frame that is not broadcast, the slave-address slot gives NAK when the received slave address differs from `my_addr`.
- R4: If `tim_err` is high in any cycle of a field while a frame is active, that field's acknowledge slot gives NAK. For the master address, the NAK appears at the slave-address slot.
- R5: Control codes 1H, 2H, 8H, 9H, CH and DH are undefined and give NAK at the control slot.
- R6: At the control slot, a code with bit 3 set gives NAK while `rx_empty` is 0. Code 3H or 7H gives NAK while `tx_empty` is 1.
- R7: While a lock is held, codes 3H, 6H, 7H, AH, BH, EH and FH give NAK when the master address differs from the lock owner. The lock owner itself gets ACK. Code 0H is never refused because of the lock.
- R8: Control code 4H gives NAK when no lock is held.
- R9: A `lock_set` pulse loads the owner from `lock_owner` and sets the lock. A `lock_rel` pulse clears the lock. If both arrive in the same cycle, the release wins.
- R10: A NAK on a frame that is not broadcast raises `frame_err` for one cycle, together with the NAK. `err_field` reports the aborting field: 1 for slave address, 2 for control, 3 for byte count, 4 for data. Until the next `sof`, no bit produces an acknowledge.
- R11: On a broadcast frame (`bcast` high at `sof`), the address match is skipped. A NAK still appears on `ack_nak`, but the frame neither aborts nor raises `frame_err`.
- R12: The byte count gives the number of data bytes. `frame_done` pulses together with the last data acknowledge, or with the byte-count acknowledge when the count is 0.
- R13: `bit_ready` is low exactly in the cycles where `ack_valid` is high. An offered bit waits until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| my_addr | input | 12 | Address of this station |
| sof | input | 1 | Start-of-frame strobe |
| bcast | input | 1 | Broadcast flag, sampled with sof |
| bit_valid | input | 1 | Received bit is offered |
| bit_data | input | 1 | Received bit value, MSB of each field first |
| bit_ready | output | 1 | Unit can take a bit this cycle |
| tim_err | input | 1 | Bit timing error in the current field |
| rx_empty | input | 1 | Local receive buffer is empty |
| tx_empty | input | 1 | Local transmit buffer is empty |
| lock_set | input | 1 | Load lock owner and set the lock |
| lock_rel | input | 1 | Release the lock |
| lock_owner | input | 12 | Owner address loaded by lock_set |
| ack_valid | output | 1 | Acknowledge decision is present |
| ack_nak | output | 1 | 0 for ACK, 1 for NAK |
| frame_err | output | 1 | One-cycle frame abort pulse |
| err_field | output | 3 | Field that caused the last abort |
| frame_done | output | 1 | One-cycle pulse when a frame completes |

## Verification
A field counter that has drifted puts the acknowledge pulse at the wrong bit. This shows up as a missing or misplaced `ack_valid` within one field, often as early as the slave-address slot. A wrong lock register or wrong control-rule state shows up only when a control field arrives, as an inverted `ack_nak` at that slot. So the lock is exercised across several frames with different masters. A stuck abort state shows up as acknowledges that are missing after the next `sof`, or as acknowledges that still appear before it.

// File: rtl/ackdec_pkg.sv
package ackdec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_MADDR = 3'd1,
    ST_SADDR = 3'd2,
    ST_CTRL  = 3'd3,
    ST_LEN   = 3'd4,
    ST_DATA  = 3'd5
  } ackdec_state_e;

  typedef enum logic [2:0] {
    FLD_NONE  = 3'd0,
    FLD_SADDR = 3'd1,
    FLD_CTRL  = 3'd2,
    FLD_LEN   = 3'd3,
    FLD_DATA  = 3'd4
  } ackdec_field_e;

  // codes that name an operation this station knows
  function automatic logic code_known(input logic [3:0] c);
    case (c)
      4'h0, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7,
      4'hA, 4'hB, 4'hE, 4'hF: code_known = 1'b1;
      default:                code_known = 1'b0;
    endcase
  endfunction

  // codes refused to foreign masters while a lock is held
  function automatic logic code_lock_guarded(input logic [3:0] c);
    case (c)
      4'h3, 4'h6, 4'h7, 4'hA, 4'hB, 4'hE, 4'hF: code_lock_guarded = 1'b1;
      default:                                  code_lock_guarded = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ackdec_collect.sv
module ackdec_collect #(
  parameter int SHW = 12,
  parameter int CW  = $clog2(SHW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic           take,
  input  logic           bit_in,
  input  logic [CW-1:0]  width,
  output logic           last,
  output logic           par_ok,
  output logic [SHW-1:0] value
);

  logic [CW-1:0]  cnt_q;
  logic [SHW-1:0] shreg_q;
  logic           par_q;

  // the bit taken when the count equals the field width is the parity bit
  assign last   = take && (cnt_q == width);
  assign par_ok = ~(par_q ^ bit_in);
  assign value  = shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
    end else if (restart) begin
      cnt_q   <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
    end else if (take) begin
      if (last) begin
        cnt_q   <= '0;
        shreg_q <= '0;
        par_q   <= 1'b0;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
        shreg_q <= {shreg_q[SHW-2:0], bit_in};
        par_q   <= par_q ^ bit_in;
      end
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(SHW));

endmodule

// File: rtl/ackdec_lock.sv
module ackdec_lock #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic          rel_i,
  input  logic [AW-1:0] owner_in,
  output logic          locked,
  output logic [AW-1:0] owner
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      owner  <= '0;
    end else if (rel_i) begin
      locked <= 1'b0;
      owner  <= '0;
    end else if (set_i) begin
      locked <= 1'b1;
      owner  <= owner_in;
    end
  end

  // R9
  lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_i |=> !locked);

  // R9
  lock_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !rel_i) |=> (locked && owner == $past(owner_in)));

endmodule

// File: rtl/ackdec_judge.sv
module ackdec_judge
  import ackdec_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [3:0]    code,
  input  logic [AW-1:0] master,
  input  logic          locked,
  input  logic [AW-1:0] owner,
  input  logic          rx_empty,
  input  logic          tx_empty,
  output logic          refuse
);

  logic undefined, write_busy, read_dry, lock_denied, lock_absent;

  always_comb begin
    undefined   = !code_known(code);
    write_busy  = code[3] && !rx_empty;
    read_dry    = ((code == 4'h3) || (code == 4'h7)) && tx_empty;
    lock_denied = locked && (master != owner) && code_lock_guarded(code);
    lock_absent = (code == 4'h4) && !locked;
    refuse      = undefined | write_busy | read_dry | lock_denied | lock_absent;
  end

endmodule

// File: rtl/ackdec_unit.sv
module ackdec_unit
  import ackdec_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] my_addr,
  input  logic              sof,
  input  logic              bcast,
  input  logic              bit_valid,
  input  logic              bit_data,
  output logic              bit_ready,
  input  logic              tim_err,
  input  logic              rx_empty,
  input  logic              tx_empty,
  input  logic              lock_set,
  input  logic              lock_rel,
  input  logic [ADDR_W-1:0] lock_owner,
  output logic              ack_valid,
  output logic              ack_nak,
  output logic              frame_err,
  output logic [2:0]        err_field,
  output logic              frame_done
);

  localparam int CTRL_W = 4;
  localparam int SHW0   = (ADDR_W > LEN_W) ? ADDR_W : LEN_W;
  localparam int SHW    = (SHW0 > DATA_W) ? SHW0 : DATA_W;
  localparam int CW     = $clog2(SHW + 1);

  ackdec_state_e     state_q;
  ackdec_field_e     err_q;
  logic              bcast_q, mbad_q, terr_q;
  logic [ADDR_W-1:0] master_q;
  logic [LEN_W-1:0]  left_q;

  logic              take, last, par_ok, refuse, locked, nak_c, terr_now;
  logic [SHW-1:0]    value;
  logic [CW-1:0]     width;
  logic [ADDR_W-1:0] owner;
  ackdec_field_e     fld_c;

  assign bit_ready = !ack_valid;
  assign take      = bit_valid && bit_ready && (state_q != ST_IDLE) && !sof;
  assign terr_now  = terr_q | tim_err;
  assign err_field = err_q;

  always_comb begin
    case (state_q)
      ST_MADDR, ST_SADDR: width = CW'(ADDR_W);
      ST_CTRL:            width = CW'(CTRL_W);
      ST_LEN:             width = CW'(LEN_W);
      default:            width = CW'(DATA_W);
    endcase
  end

  ackdec_collect #(.SHW(SHW), .CW(CW)) u_collect (
    .clk(clk), .rst_n(rst_n), .restart(sof), .take(take), .bit_in(bit_data),
    .width(width), .last(last), .par_ok(par_ok), .value(value)
  );

  ackdec_lock #(.AW(ADDR_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .set_i(lock_set), .rel_i(lock_rel),
    .owner_in(lock_owner), .locked(locked), .owner(owner)
  );

  ackdec_judge #(.AW(ADDR_W)) u_judge (
    .code(value[CTRL_W-1:0]), .master(master_q), .locked(locked), .owner(owner),
    .rx_empty(rx_empty), .tx_empty(tx_empty), .refuse(refuse)
  );

  always_comb begin
    nak_c = !par_ok || terr_now;
    fld_c = FLD_DATA;
    case (state_q)
      ST_SADDR: begin
        nak_c = nak_c || mbad_q || (!bcast_q && (value[ADDR_W-1:0] != my_addr));
        fld_c = FLD_SADDR;
      end
      ST_CTRL: begin
        nak_c = nak_c || refuse;
        fld_c = FLD_CTRL;
      end
      ST_LEN:  fld_c = FLD_LEN;
      default: fld_c = FLD_DATA;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      err_q      <= FLD_NONE;
      bcast_q    <= 1'b0;
      mbad_q     <= 1'b0;
      terr_q     <= 1'b0;
      master_q   <= '0;
      left_q     <= '0;
      ack_valid  <= 1'b0;
      ack_nak    <= 1'b0;
      frame_err  <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      ack_valid  <= 1'b0;
      frame_err  <= 1'b0;
      frame_done <= 1'b0;
      if (sof) begin
        state_q <= ST_MADDR;
        bcast_q <= bcast;
        mbad_q  <= 1'b0;
        terr_q  <= 1'b0;
      end else begin
        if (state_q != ST_IDLE && tim_err) terr_q <= 1'b1;
        if (last) begin
          terr_q <= 1'b0;
          if (state_q == ST_MADDR) begin
            master_q <= value[ADDR_W-1:0];
            mbad_q   <= !par_ok || terr_now;
            state_q  <= ST_SADDR;
          end else begin
            ack_valid <= 1'b1;
            ack_nak   <= nak_c;
            if (nak_c && !bcast_q) begin
              state_q   <= ST_IDLE;
              frame_err <= 1'b1;
              err_q     <= fld_c;
            end else begin
              case (state_q)
                ST_SADDR: state_q <= ST_CTRL;
                ST_CTRL:  state_q <= ST_LEN;
                ST_LEN: begin
                  if (value[LEN_W-1:0] == '0) begin
                    state_q    <= ST_IDLE;
                    frame_done <= 1'b1;
                  end else begin
                    left_q  <= value[LEN_W-1:0];
                    state_q <= ST_DATA;
                  end
                end
                default: begin
                  if (left_q == LEN_W'(1)) begin
                    state_q    <= ST_IDLE;
                    frame_done <= 1'b1;
                  end
                  left_q <= left_q - 1'b1;
                end
              endcase
            end
          end
        end
      end
    end
  end

  // R10
  abort_with_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> (ack_valid && ack_nak));

  // R10
  abort_goes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> (state_q == ST_IDLE));

  // R11
  bcast_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !bcast_q);

  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> !ack_valid);

  // R2
  ack_follows_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_valid) |-> $past(bit_valid));

  // R12
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_err, frame_done}));

endmodule

// File: tb/ackdec_unit_test.sv
module ackdec_unit_test;

  localparam logic [11:0] MY = 12'h2A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0, bcast = 1'b0, bit_valid = 1'b0, bit_data = 1'b0;
  logic        tim_err = 1'b0, rx_empty = 1'b1, tx_empty = 1'b0;
  logic        lock_set = 1'b0, lock_rel = 1'b0;
  logic [11:0] lock_owner = '0;
  logic        bit_ready, ack_valid, ack_nak, frame_err, frame_done;
  logic [2:0]  err_field;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  ackdec_unit uut (
    .clk(clk), .rst_n(rst_n), .my_addr(MY), .sof(sof), .bcast(bcast),
    .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
    .tim_err(tim_err), .rx_empty(rx_empty), .tx_empty(tx_empty),
    .lock_set(lock_set), .lock_rel(lock_rel), .lock_owner(lock_owner),
    .ack_valid(ack_valid), .ack_nak(ack_nak), .frame_err(frame_err),
    .err_field(err_field), .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the bit is taken
  task automatic put_bit(input logic b, input logic te);
    while (!bit_ready) @(negedge clk);
    bit_valid = 1'b1; bit_data = b; tim_err = te;
    @(negedge clk);
    bit_valid = 1'b0; tim_err = 1'b0;
  endtask

  task automatic send_field(input logic [11:0] v, input int w, input bit badpar, input bit te);
    logic p = badpar;
    for (int i = w - 1; i >= 0; i--) begin
      p = p ^ v[i];
      put_bit(v[i], te && (i == 0));
    end
    put_bit(p, 1'b0);
  endtask

  task automatic start(input logic bc);
    sof = 1'b1; bcast = bc;
    @(negedge clk);
    sof = 1'b0; bcast = 1'b0;
  endtask

  task automatic expect_ack(input logic nak, input logic err, input string tag);
    chk(ack_valid == 1'b1, {tag, " ack_valid"}, int'(ack_valid), 1);
    chk(ack_nak == nak, {tag, " ack_nak"}, int'(ack_nak), int'(nak));
    chk(frame_err == err, {tag, " frame_err"}, int'(frame_err), int'(err));
  endtask

  task automatic header(input logic [11:0] m, input logic [11:0] s, input logic [3:0] c,
                        input logic nak, input string tag);
    start(1'b0);
    send_field(m, 12, 0, 0);
    chk(ack_valid == 1'b0, "R2 no ack after master address", int'(ack_valid), 0);
    send_field(s, 12, 0, 0);
    expect_ack(1'b0, 1'b0, "R2 slave ack");
    send_field({8'h0, c}, 4, 0, 0);
    expect_ack(nak, nak, tag);
  endtask

  task automatic t_reset;
    chk(ack_valid == 0 && frame_err == 0 && frame_done == 0, "reset outputs", int'(ack_valid), 0);
    chk(bit_ready == 1, "R13 ready after reset", int'(bit_ready), 1);
  endtask

  task automatic t_good_write;
    rx_empty = 1'b1;
    header(12'h123, MY, 4'hA, 1'b0, "R6 write with empty rx");
    chk(bit_ready == 0, "R13 ready low in ack cycle", int'(bit_ready), 0);
    send_field(12'h2, 8, 0, 0);
    expect_ack(1'b0, 1'b0, "R12 length ack");
    send_field(12'h5A, 8, 0, 0);
    expect_ack(1'b0, 1'b0, "R2 data ack");
    chk(frame_done == 0, "R12 no done early", int'(frame_done), 0);
    send_field(12'hC3, 8, 0, 0);
    expect_ack(1'b0, 1'b0, "R2 data ack last");
    chk(frame_done == 1, "R12 done on last byte", int'(frame_done), 1);
  endtask

  task automatic t_addr_mismatch;
    start(1'b0);
    send_field(12'h123, 12, 0, 0);
    send_field(12'h2A4, 12, 0, 0);
    expect_ack(1'b1, 1'b1, "R3 address mismatch");
    chk(err_field == 3'd1, "R10 err_field slave", int'(err_field), 1);
    send_field(12'h3, 4, 0, 0);
    chk(ack_valid == 0, "R10 bits ignored after abort", int'(ack_valid), 0);
  endtask

  task automatic t_parity;
    start(1'b0);
    send_field(12'h123, 12, 1, 0);
    send_field(MY, 12, 0, 0);
    expect_ack(1'b1, 1'b1, "R1 master parity at slave slot");
    start(1'b0);
    send_field(12'h123, 12, 0, 0);
    send_field(MY, 12, 0, 0);
    expect_ack(1'b0, 1'b0, "R1 good addresses");
    send_field(12'h0, 4, 1, 0);
    expect_ack(1'b1, 1'b1, "R1 control parity");
    chk(err_field == 3'd2, "R10 err_field control", int'(err_field), 2);
  endtask

  task automatic t_codes;
    header(12'h123, MY, 4'h1, 1'b1, "R5 undefined 1H");
    header(12'h123, MY, 4'hD, 1'b1, "R5 undefined DH");
    rx_empty = 1'b0;
    header(12'h123, MY, 4'hE, 1'b1, "R6 write with busy rx");
    header(12'h123, MY, 4'h6, 1'b0, "R6 bit3 clear ok with busy rx");
    rx_empty = 1'b1;
    tx_empty = 1'b1;
    header(12'h123, MY, 4'h7, 1'b1, "R6 read with empty tx");
    tx_empty = 1'b0;
    header(12'h123, MY, 4'h3, 1'b0, "R6 read with filled tx");
  endtask

  task automatic t_lock;
    header(12'h456, MY, 4'h4, 1'b1, "R8 lock read unlocked");
    lock_owner = 12'h123; lock_set = 1'b1;
    @(negedge clk);
    lock_set = 1'b0;
    header(12'h456, MY, 4'h6, 1'b1, "R7 foreign master 6H");
    header(12'h123, MY, 4'h6, 1'b0, "R7 owner 6H");
    header(12'h456, MY, 4'h0, 1'b0, "R7 foreign master 0H");
    header(12'h456, MY, 4'h4, 1'b0, "R8 lock read locked");
    lock_owner = 12'h456; lock_set = 1'b1; lock_rel = 1'b1;
    @(negedge clk);
    lock_set = 1'b0; lock_rel = 1'b0;
    header(12'h456, MY, 4'h4, 1'b1, "R9 release wins over set");
    header(12'h789, MY, 4'hB, 1'b0, "R9 unlocked after release");
  endtask

  task automatic t_timing;
    header(12'h123, MY, 4'h0, 1'b0, "R4 header");
    send_field(12'h1, 8, 0, 1);
    expect_ack(1'b1, 1'b1, "R4 timing error in length");
    chk(err_field == 3'd3, "R10 err_field length", int'(err_field), 3);
    header(12'h123, MY, 4'h0, 1'b0, "R4 header2");
    send_field(12'h1, 8, 0, 0);
    expect_ack(1'b0, 1'b0, "R4 length");
    send_field(12'h11, 8, 1, 0);
    expect_ack(1'b1, 1'b1, "R1 data parity");
    chk(err_field == 3'd4, "R10 err_field data", int'(err_field), 4);
  endtask

  task automatic t_bcast;
    start(1'b1);
    send_field(12'h123, 12, 0, 0);
    send_field(12'hFFF, 12, 0, 0);
    expect_ack(1'b0, 1'b0, "R11 broadcast skips match");
    send_field(12'h9, 4, 0, 0);
    expect_ack(1'b1, 1'b0, "R11 broadcast nak no abort");
    send_field(12'h1, 8, 0, 0);
    expect_ack(1'b0, 1'b0, "R11 broadcast length");
    send_field(12'h77, 8, 1, 0);
    expect_ack(1'b1, 1'b0, "R11 broadcast bad data");
    chk(frame_done == 1, "R11 broadcast completes", int'(frame_done), 1);
  endtask

  task automatic t_len_zero;
    header(12'h123, MY, 4'h5, 1'b0, "R12 header");
    send_field(12'h0, 8, 0, 0);
    expect_ack(1'b0, 1'b0, "R12 zero length ack");
    chk(frame_done == 1, "R12 done on zero length", int'(frame_done), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good_write();
    t_addr_mismatch();
    t_parity();
    t_codes();
    t_lock();
    t_timing();
    t_bcast();
    t_len_zero();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule